// File: doc/BRIEF.md
# Link Acknowledge ID Tracker

This block is the transmit-side reliability logic of a single point-to-point link. Every packet the transmitter sends receives a sequence number (the acknowledge ID), counting upward and wrapping at the ID width. The block records which IDs are still awaiting acknowledgement. It consumes the acknowledge control symbols that the far end returns, and each symbol carries an ID, an accept/reject flag and the receiver's free-buffer count. Acknowledgements must come back in the order the packets left. A matching accept retires the oldest outstanding packet. An accept for any other ID is reported as an ordering error and retires nothing.

A reject symbol, or a stretch of time in which the oldest packet sees no acknowledgement, starts a replay. The block raises a one-cycle retransmit request that names the oldest unacknowledged ID, clears its outstanding record and rewinds its next-ID counter to that ID. The packet source then resends from there through the normal issue handshake. Issue stalls when the ID window is full or when the receiver has reported no free buffers. Packet storage, CRC checking and the link-recovery symbol exchange sit outside this block.

The control is a three-state machine. ST_IDLE holds while nothing is outstanding. ST_BUSY holds while at least one packet is outstanding. ST_RECOVER lasts exactly one cycle and drives the retransmit request. The transitions are: idle_to_busy on an accepted issue; busy_to_idle when the last outstanding packet retires and nothing new is issued; busy_to_recover on a reject or a timeout; recover_to_idle, which is unconditional on the next cycle.

Top module: `ackt_tracker`

## Requirements
- R1: After reset, issue_ready is 1 (the initial room is nonzero), issue_id is 0, and retx_req, err_order and err_timeout are 0.
- R2: An issue is accepted when issue_valid and issue_ready are both 1. The accepted packet takes issue_id, and issue_id then advances by one modulo 2^IDW.
- R3: While 2^IDW-1 packets are outstanding, issue_ready is 0.
- R4: An accept symbol (sym_valid=1, sym_nack=0) whose sym_id equals the oldest outstanding ID retires that packet. This frees one place in the window.
- R5: An accept symbol whose ID is not the oldest outstanding ID, or that arrives when nothing is outstanding, retires nothing. err_order is 1 for exactly the following cycle.
- R6: A reject symbol (sym_valid=1, sym_nack=1) that arrives while packets are outstanding drives retx_req to 1 for exactly the next cycle. In that cycle retx_id and issue_id both equal the oldest outstanding ID, and the outstanding record is empty. A reject that arrives with nothing outstanding has no effect on retx_req.
- R7: If TMO_CYCLES clock edges pass with packets outstanding, no retirement and no symbol at the final edge, then retx_req and err_timeout are both 1 in the next cycle. The rewind is the same as in R6.
- R8: The timeout count restarts on every retirement and stays at zero while nothing is outstanding.
- R9: While retx_req is 1, issue_ready is 0 and any symbol is ignored: no error, no retirement, no room update.
- R10: Each symbol outside recovery loads the room count from sym_room. Each accepted issue lowers the room count by one, with a floor of zero. issue_ready is 0 while the room count is zero.
- R11: An issue accepted in the same cycle as a reject or timeout trigger is discarded. issue_id after the rewind equals the oldest ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Source offers a packet |
| issue_ready | output | 1 | Tracker can accept a packet |
| issue_id | output | IDW | ID given to the packet accepted this cycle |
| sym_valid | input | 1 | Acknowledge symbol present |
| sym_nack | input | 1 | 1 = reject, 0 = accept |
| sym_id | input | IDW | ID carried by the symbol |
| sym_room | input | ROOMW | Receiver free-buffer count |
| retx_req | output | 1 | One-cycle replay request |
| retx_id | output | IDW | First ID to resend |
| err_order | output | 1 | Out-of-order acknowledgement pulse |
| err_timeout | output | 1 | Missing-acknowledgement pulse |

## Verification
The bench builds the tracker with IDW=3, so a full seven-packet window and the wrap of the ID from 7 to 0 occur within a few dozen issues. TMO_CYCLES=24 makes timeouts occur often during a phase with few symbols. INIT_ROOM=6, together with random sym_room values that include zero, makes room stalls and window-full stalls both common. With these values every state transition, and the trigger-cycle discard of an issue, occurs many times over several thousand cycles.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSY    = 2'd1,
        ST_RECOVER = 2'd2
    } ackt_state_e;
endpackage

// File: rtl/ackt_window.sv
module ackt_window #(
    parameter int unsigned IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic           rewind,
    output logic [IDW-1:0] next_id,
    output logic [IDW-1:0] oldest_id,
    output logic [IDW-1:0] count,
    output logic           full,
    output logic           empty
);
    localparam int unsigned WIN = (1 << IDW) - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_id   <= '0;
            oldest_id <= '0;
            count     <= '0;
        end else if (rewind) begin
            next_id <= oldest_id;
            count   <= '0;
        end else begin
            if (push) next_id   <= next_id + 1'b1;
            if (pop)  oldest_id <= oldest_id + 1'b1;
            count <= count + IDW'(push) - IDW'(pop);
        end
    end

    assign full  = (count == IDW'(WIN));
    assign empty = (count == '0);
endmodule

// File: rtl/ackt_timer.sv
module ackt_timer #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    output logic                     expired,
    output logic [$clog2(LIMIT)-1:0] cnt_o
);
    localparam int unsigned CW = $clog2(LIMIT);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_o <= '0;
        else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
    end

    assign expired = (cnt_o == TOP);
endmodule

// File: rtl/ackt_credit.sv
module ackt_credit #(
    parameter int unsigned RW   = 4,
    parameter int unsigned INIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] load_val,
    input  logic          take,
    output logic [RW-1:0] room,
    output logic          avail
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            room <= RW'(INIT);
        end else if (load) begin
            room <= (take && load_val != '0) ? load_val - 1'b1 : load_val;
        end else if (take && room != '0) begin
            room <= room - 1'b1;
        end
    end

    assign avail = (room != '0);
endmodule

// File: rtl/ackt_tracker.sv
module ackt_tracker
    import ackt_pkg::*;
#(
    parameter int unsigned IDW        = 3,
    parameter int unsigned ROOMW      = 4,
    parameter int unsigned INIT_ROOM  = 8,
    parameter int unsigned TMO_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    output logic             issue_ready,
    output logic [IDW-1:0]   issue_id,
    input  logic             sym_valid,
    input  logic             sym_nack,
    input  logic [IDW-1:0]   sym_id,
    input  logic [ROOMW-1:0] sym_room,
    output logic             retx_req,
    output logic [IDW-1:0]   retx_id,
    output logic             err_order,
    output logic             err_timeout
);
    localparam int unsigned TW = $clog2(TMO_CYCLES);

    ackt_state_e state_q, state_d;

    logic [IDW-1:0]   oldest_id, win_count;
    logic             win_full, win_empty;
    logic [TW-1:0]    tmr_cnt;
    logic             tmr_expired;
    logic [ROOMW-1:0] room_q;
    logic             room_avail;

    logic sym_ok, ack_hit, ack_bad, nack_trig, tmo_trig, trig;
    logic fire, push, pop;

    // symbol decode; symbols are dropped during the recovery cycle
    assign sym_ok    = sym_valid && (state_q != ST_RECOVER);
    assign ack_hit   = sym_ok && !sym_nack && !win_empty && (sym_id == oldest_id);
    assign ack_bad   = sym_ok && !sym_nack && !ack_hit;
    assign nack_trig = sym_ok && sym_nack && !win_empty;
    assign tmo_trig  = (state_q != ST_RECOVER) && !sym_valid && !win_empty && tmr_expired;
    assign trig      = nack_trig || tmo_trig;

    assign fire = issue_valid && issue_ready;
    assign push = fire && !trig;
    assign pop  = ack_hit;

    ackt_window #(.IDW(IDW)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .rewind    (trig),
        .next_id   (issue_id),
        .oldest_id (oldest_id),
        .count     (win_count),
        .full      (win_full),
        .empty     (win_empty)
    );

    ackt_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pop || trig || win_empty),
        .expired (tmr_expired),
        .cnt_o   (tmr_cnt)
    );

    ackt_credit #(.RW(ROOMW), .INIT(INIT_ROOM)) u_cred (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sym_ok),
        .load_val (sym_room),
        .take     (push),
        .room     (room_q),
        .avail    (room_avail)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (push) state_d = ST_BUSY;            // idle_to_busy
            end
            ST_BUSY: begin
                if (trig)
                    state_d = ST_RECOVER;               // busy_to_recover
                else if (pop && !push && win_count == IDW'(1))
                    state_d = ST_IDLE;                  // busy_to_idle
            end
            ST_RECOVER: state_d = ST_IDLE;              // recover_to_idle
            default:    state_d = ST_IDLE;
        endcase
    end

    // registered pulses and replay ID
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retx_id     <= '0;
            err_order   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            if (trig) retx_id <= oldest_id;
            err_order   <= ack_bad;
            err_timeout <= tmo_trig;
        end
    end

    // state-driven outputs
    always_comb begin
        retx_req    = (state_q == ST_RECOVER);
        issue_ready = (state_q != ST_RECOVER) && !win_full && room_avail;
    end
endmodule

// File: rtl/ackt_tracker_chk.sv
module ackt_tracker_chk #(
    parameter int unsigned IDW   = 3,
    parameter int unsigned ROOMW = 4,
    parameter int unsigned TW    = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_ready,
    input logic [IDW-1:0]   issue_id,
    input logic             sym_valid,
    input logic             sym_nack,
    input logic             retx_req,
    input logic [IDW-1:0]   retx_id,
    input logic             err_order,
    input logic             err_timeout,
    input logic [IDW-1:0]   win_count,
    input logic [TW-1:0]    tmr_cnt,
    input logic [ROOMW-1:0] room_q
);
    localparam int unsigned WIN = (1 << IDW) - 1;

    // R3
    window_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_count == IDW'(WIN)) |-> !issue_ready);

    // R6
    retx_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |=> !retx_req);

    // R6
    retx_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |-> (issue_id == retx_id && win_count == '0));

    // R9
    recover_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |-> !issue_ready);

    // R5
    order_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_order |-> $past(sym_valid && !sym_nack));

    // R7
    timeout_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> retx_req);

    // R8
    timer_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_count == '0) |-> (tmr_cnt == '0));

    // R10
    room_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (room_q == '0) |-> !issue_ready);
endmodule

bind ackt_tracker ackt_tracker_chk #(
    .IDW   (IDW),
    .ROOMW (ROOMW),
    .TW    ($clog2(TMO_CYCLES))
) u_ackt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_ready (issue_ready),
    .issue_id    (issue_id),
    .sym_valid   (sym_valid),
    .sym_nack    (sym_nack),
    .retx_req    (retx_req),
    .retx_id     (retx_id),
    .err_order   (err_order),
    .err_timeout (err_timeout),
    .win_count   (win_count),
    .tmr_cnt     (tmr_cnt),
    .room_q      (room_q)
);

// File: tb/tb_ackt_tracker.sv
module tb_ackt_tracker;
    localparam int unsigned IDW   = 3;
    localparam int unsigned ROOMW = 4;
    localparam int unsigned IROOM = 6;
    localparam int unsigned TMO   = 24;
    localparam int unsigned WIN   = (1 << IDW) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue_valid = 1'b0;
    logic             issue_ready;
    logic [IDW-1:0]   issue_id;
    logic             sym_valid = 1'b0;
    logic             sym_nack = 1'b0;
    logic [IDW-1:0]   sym_id = '0;
    logic [ROOMW-1:0] sym_room = '0;
    logic             retx_req;
    logic [IDW-1:0]   retx_id;
    logic             err_order;
    logic             err_timeout;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ackt_tracker #(
        .IDW(IDW), .ROOMW(ROOMW), .INIT_ROOM(IROOM), .TMO_CYCLES(TMO)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_id(issue_id),
        .sym_valid(sym_valid), .sym_nack(sym_nack), .sym_id(sym_id), .sym_room(sym_room),
        .retx_req(retx_req), .retx_id(retx_id),
        .err_order(err_order), .err_timeout(err_timeout)
    );

    // reference model, built from the requirements
    logic [IDW-1:0]   m_next, m_old, m_retx;
    logic [ROOMW-1:0] m_room;
    int               m_cnt, m_tmr;
    logic             m_rec, m_eo, m_et;

    function automatic logic m_ready();
        return !m_rec && (m_cnt < WIN) && (m_room != 0);
    endfunction

    task automatic m_step();
        logic fire, trig, pop, eo, et, okv;
        fire = issue_valid && m_ready();
        trig = 0; pop = 0; eo = 0; et = 0;
        okv  = sym_valid && !m_rec;
        if (okv) begin
            if (sym_nack) trig = (m_cnt != 0);
            else if (m_cnt != 0 && sym_id == m_old) pop = 1;
            else eo = 1;
        end else if (!m_rec && !sym_valid && m_cnt != 0 && m_tmr == TMO - 1) begin
            trig = 1; et = 1;
        end
        // room (R10)
        if (okv) m_room = (fire && !trig && sym_room != 0) ? sym_room - 1'b1 : sym_room;
        else if (fire && !trig && m_room != 0) m_room = m_room - 1'b1;
        // timer (R8)
        if (pop || trig || m_cnt == 0) m_tmr = 0;
        else if (m_tmr != TMO - 1) m_tmr = m_tmr + 1;
        if (trig) begin
            m_retx = m_old; m_next = m_old; m_cnt = 0;
        end else begin
            if (fire) m_next = m_next + 1'b1;
            if (pop)  m_old  = m_old + 1'b1;
            m_cnt = m_cnt + int'(fire) - int'(pop);
        end
        m_rec = trig;
        m_eo  = eo;
        m_et  = et;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_next = '0; m_old = '0; m_retx = '0; m_room = ROOMW'(IROOM);
            m_cnt = 0; m_tmr = 0; m_rec = 0; m_eo = 0; m_et = 0;
        end else begin
            m_step();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 issue_id", int'(issue_id), int'(m_next));
        chk("R3 R10 issue_ready", int'(issue_ready), int'(m_ready()));
        chk("R6 retx_req", int'(retx_req), int'(m_rec));
        if (m_rec) chk("R6 retx_id", int'(retx_id), int'(m_retx));
        chk("R5 err_order", int'(err_order), int'(m_eo));
        chk("R7 err_timeout", int'(err_timeout), int'(m_et));
    endtask

    // drive one cycle at the falling edge, compare at the next falling edge
    task automatic cyc(input logic iv, input logic sv, input logic sn,
                       input logic [IDW-1:0] sid, input logic [ROOMW-1:0] sr);
        issue_valid = iv; sym_valid = sv; sym_nack = sn; sym_id = sid; sym_room = sr;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 60000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int seed;
        logic [IDW-1:0] rid;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 issue_ready", int'(issue_ready), 1);
        chk("R1 issue_id", int'(issue_id), 0);
        chk("R1 retx_req", int'(retx_req), 0);
        chk("R1 errors", int'(err_order | err_timeout), 0);

        // R6: reject with nothing outstanding is ignored; it also loads room 15 (R10)
        cyc(0, 1, 1, 0, 15);
        chk("R6 idle reject retx_req", int'(retx_req), 0);
        chk("R5 idle reject no order error", int'(err_order), 0);

        // R3: fill the window
        for (int i = 0; i < WIN; i++) cyc(1, 0, 0, 0, 0);
        chk("R3 window full ready", int'(issue_ready), 0);
        chk("R2 next id after fill", int'(issue_id), 7);

        // R5: wrong ID retires nothing
        cyc(0, 1, 0, 5, 15);
        chk("R5 order error pulse", int'(err_order), 1);
        chk("R5 nothing retired", int'(issue_ready), 0);

        // R4: oldest ID retires
        cyc(0, 1, 0, 0, 15);
        chk("R4 retire frees slot", int'(issue_ready), 1);

        // R8 / R7: timer restarted by the retire, then expires after TMO edges
        for (int i = 0; i < TMO - 1; i++) cyc(0, 0, 0, 0, 0);
        chk("R8 no timeout before limit", int'(retx_req), 0);
        cyc(0, 0, 0, 0, 0);
        chk("R7 timeout flag", int'(err_timeout), 1);
        chk("R7 replay id", int'(retx_id), 1);
        chk("R7 rewind issue_id", int'(issue_id), 1);

        // R9: during the replay cycle, stall and ignore symbols
        chk("R9 ready low in replay", int'(issue_ready), 0);
        cyc(1, 1, 0, 1, 0);
        chk("R9 symbol ignored", int'(err_order), 0);
        chk("R9 issue ignored", int'(issue_id), 1);
        chk("R9 room untouched", int'(issue_ready), 1);

        // R11: issue in the reject trigger cycle is discarded
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 1, 1, 3, 15);
        chk("R11 replay raised", int'(retx_req), 1);
        chk("R11 issue discarded", int'(issue_id), 1);

        // R10: room reaches zero and stalls issue
        cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 0, 6, 2);   // bogus ack loads 2, issue takes one -> 1
        cyc(1, 0, 0, 0, 0);   // -> 0
        chk("R10 room exhausted", int'(issue_ready), 0);

        // random phase with frequent symbols
        for (int i = 0; i < 3000; i++) begin
            rid = ($urandom % 4 != 0) ? m_old : IDW'($urandom);
            cyc(($urandom % 3) != 0, ($urandom % 10) < 4, ($urandom % 8) == 0,
                rid, ROOMW'($urandom % 16));
        end
        // random phase with rare symbols so timeouts occur (R7)
        for (int i = 0; i < 3000; i++) begin
            rid = ($urandom % 5 != 0) ? m_old : IDW'($urandom);
            cyc(($urandom % 4) == 0, ($urandom % 50) == 0, ($urandom % 6) == 0,
                rid, ROOMW'(4 + $urandom % 12));
        end
        finish_run();
    end
endmodule